// File: doc/BRIEF.md
# Serial Memory Command Slave

This block is the slave end of a four-wire serial link to a byte-wide nonvolatile memory of 2048 bytes. All activity runs on one system clock. The serial clock, select, data input and pause inputs are brought into that domain and their edges are detected there. A command begins when select falls. The first eight bits form an opcode. Read and write commands then take a 16-bit address.

Reads are served from a registered array read port and stream out byte after byte. The status byte comes from a status input, and a busy input forces it to all ones. The write-related commands are not carried out here. They are passed to a separate write engine as one-cycle strobes that carry the address and data. The serial output has its own enable, so the pad can float whenever the slave is not talking.

The system clock must run at least eight times faster than the serial clock.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `so_oe_o` is low and no strobe output (`wren_o`, `wrdi_o`, `wrsr_o`, `wbyte_o`, `cmd_end_o`) is asserted.
- R2: Input bits are taken on rising serial clock edges, MSB first. Opcode 0x06 gives one `wren_o` pulse and opcode 0x04 gives one `wrdi_o` pulse. At most one of `wren_o`, `wrdi_o`, `wrsr_o` and `wbyte_o` is high in any cycle, and the output stays disabled for these commands.
- R3: Opcode 0x03 is followed by a 16-bit address, MSB first, of which only the low 11 bits are used. The addressed byte is then shifted out MSB first, and `so_o` changes only after falling serial clock edges.
- R4: During a read, the address advances by one after each byte and wraps from 0x7FF to 0x000. Reading continues for as long as clocks arrive.
- R5: Opcode 0x05 shifts out `status_i` and repeats it for every further byte. When `busy_i` is high at the moment a byte is loaded, that whole byte reads 0xFF.
- R6: While `busy_i` is high, every opcode other than 0x05 is ignored. No strobe is produced and the output stays disabled until select rises.
- R7: An opcode outside the six defined values (0x06, 0x04, 0x05, 0x01, 0x03, 0x02) causes everything up to the next select falling edge to be ignored. No strobe is produced and the output stays disabled.
- R8: Opcode 0x02 is followed by a 16-bit address. Each complete data byte then gives one `wbyte_o` pulse with `wr_addr_o` and `wr_data_o`. The address increments within its 32-byte page: the low 5 bits wrap and the upper bits are kept.
- R9: Opcode 0x01 followed by a full byte gives one `wrsr_o` pulse with that byte on `wr_data_o`.
- R10: The pause input taken low while the serial clock is low freezes the transfer and disables the output, and serial clock and data edges are then ignored. Taking it high while the clock is low resumes the transfer at the same bit.
- R11: While select is high the output is disabled. Every select rising edge gives one `cmd_end_o` pulse, and a partly received byte produces no strobe.
- R12: Both clock polarities that sample on the rising edge are served: idle-low (mode 0) and idle-high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| cs_n_i | input | 1 | Select, active low |
| si_i | input | 1 | Serial data from the master |
| hold_n_i | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data to the master |
| so_oe_o | output | 1 | Output enable for `so_o` |
| busy_i | input | 1 | Internal write in progress |
| status_i | input | 8 | Status byte contents |
| rd_addr_o | output | 11 | Array read address |
| rd_data_i | input | 8 | Array read data, one cycle after the address |
| wren_o | output | 1 | Write-enable command strobe |
| wrdi_o | output | 1 | Write-disable command strobe |
| wrsr_o | output | 1 | Status write strobe |
| wbyte_o | output | 1 | Data byte write strobe |
| wr_addr_o | output | 11 | Address for `wbyte_o` |
| wr_data_o | output | 8 | Data for `wbyte_o` or `wrsr_o` |
| cmd_end_o | output | 1 | Select rising edge strobe |

## Verification
Two things can happen close together: the status byte is reloaded at a byte boundary, and `busy_i` is released in the middle of a continuous status read. To make this happen, the bench starts a status read with busy high and lowers busy after four bits of the second byte. Every byte must be either all ones or the true status, never a mix. The second byte must still read 0xFF because it was loaded while busy, and the third byte must read the status value. A pause is also placed just after a falling clock edge in the data phase, so that the shift caused by that edge and the entry into the pause fall in neighbouring cycles. The resumed byte must then match the array contents bit for bit.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_RSTA = 8'h05;
  localparam logic [7:0] OP_WSTA = 8'h01;
  localparam logic [7:0] OP_RD   = 8'h03;
  localparam logic [7:0] OP_WR   = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_STAT, ST_WSR, ST_IGN
  } sm_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] qd_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic m1, m2, m3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1 <= 1'b0;
        m2 <= 1'b0;
        m3 <= 1'b0;
      end else begin
        m1 <= d_i[g];
        m2 <= m1;
        m3 <= m2;
      end
    end
    assign q_o[g]  = m2;
    assign qd_o[g] = m3;
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] byte_i,
  input  logic         shift_i,
  output logic         so_o
);
  logic [W-1:0] sr_q, sr_n;
  logic         so_q, so_n;

  always_comb begin
    sr_n = sr_q;
    so_n = so_q;
    if (load_i) begin
      sr_n = byte_i;
    end else if (shift_i) begin
      so_n = sr_q[W-1];
      sr_n = {sr_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      so_q <= 1'b0;
    end else begin
      sr_q <= sr_n;
      so_q <= so_n;
    end
  end

  assign so_o = so_q;
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int ADDR_PHASE = 16,
  parameter int PAGE_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              si_i,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              load_o,
  output logic [7:0]        load_byte_o,
  output logic              drive_o,
  output logic              wren_o,
  output logic              wrdi_o,
  output logic              wrsr_o,
  output logic              wbyte_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              cmd_end_o
);
  localparam int CNT_W = $clog2(ADDR_PHASE);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_PHASE - 1);

  sm_t               st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [7:0]        sr_q, sr_n, bit_in;
  logic [ADDR_W-2:0] ash_q, ash_n;
  logic [ADDR_W-1:0] addr_q, addr_n, waddr_q, waddr_n;
  logic [7:0]        wdat_q, wdat_n;
  logic              is_rd_q, is_rd_n, ld_req;
  logic [1:0]        ldp_q, ldp_n;
  logic              wen_n, wdis_n, wsr_n, wb_n, end_n;

  assign bit_in = {sr_q[6:0], si_i};

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sr_n = sr_q; ash_n = ash_q;
    addr_n = addr_q; waddr_n = waddr_q; wdat_n = wdat_q; is_rd_n = is_rd_q;
    ld_req = 1'b0; wen_n = 1'b0; wdis_n = 1'b0; wsr_n = 1'b0; wb_n = 1'b0;
    end_n = 1'b0;
    if (cs_fall_i) begin
      st_n  = ST_OPC;
      cnt_n = '0;
    end else if (cs_rise_i) begin
      st_n  = ST_IDLE;
      end_n = 1'b1;
    end else if (rise_i) begin
      cnt_n = cnt_q + 1'b1;
      unique case (st_q)
        ST_OPC: begin
          sr_n = bit_in;
          if (cnt_q == LAST_BIT) begin
            cnt_n = '0;
            st_n  = ST_IGN;
            if (!busy_i || bit_in == OP_RSTA) begin
              unique case (bit_in)
                OP_WEN:  wen_n = 1'b1;
                OP_WDIS: wdis_n = 1'b1;
                OP_RSTA: begin st_n = ST_STAT; ld_req = 1'b1; end
                OP_WSTA: st_n = ST_WSR;
                OP_RD:   begin st_n = ST_ADDR; is_rd_n = 1'b1; end
                OP_WR:   begin st_n = ST_ADDR; is_rd_n = 1'b0; end
                default: st_n = ST_IGN;
              endcase
            end
          end
        end
        ST_ADDR: begin
          ash_n = {ash_q[ADDR_W-3:0], si_i};
          if (cnt_q == LAST_ADDR) begin
            cnt_n  = '0;
            addr_n = {ash_q, si_i};
            st_n   = is_rd_q ? ST_RDAT : ST_WDAT;
            ld_req = is_rd_q;
          end
        end
        ST_RDAT, ST_STAT: begin
          if (cnt_q == LAST_BIT) begin
            cnt_n  = '0;
            ld_req = 1'b1;
            if (st_q == ST_RDAT) addr_n = addr_q + 1'b1;
          end
        end
        ST_WDAT, ST_WSR: begin
          sr_n = bit_in;
          if (cnt_q == LAST_BIT) begin
            cnt_n  = '0;
            wdat_n = bit_in;
            if (st_q == ST_WSR) begin
              wsr_n = 1'b1;
              st_n  = ST_IGN;
            end else begin
              wb_n    = 1'b1;
              waddr_n = addr_q;
              addr_n  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
            end
          end
        end
        default: cnt_n = cnt_q;
      endcase
    end
    ldp_n = {ldp_q[0], ld_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sr_q <= '0; ash_q <= '0;
      addr_q <= '0; waddr_q <= '0; wdat_q <= '0; is_rd_q <= 1'b0;
      ldp_q <= '0; wren_o <= 1'b0; wrdi_o <= 1'b0; wrsr_o <= 1'b0;
      wbyte_o <= 1'b0; cmd_end_o <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sr_q <= sr_n; ash_q <= ash_n;
      addr_q <= addr_n; waddr_q <= waddr_n; wdat_q <= wdat_n;
      is_rd_q <= is_rd_n; ldp_q <= ldp_n; wren_o <= wen_n; wrdi_o <= wdis_n;
      wrsr_o <= wsr_n; wbyte_o <= wb_n; cmd_end_o <= end_n;
    end
  end

  assign rd_addr_o   = addr_q;
  assign wr_addr_o   = waddr_q;
  assign wr_data_o   = wdat_q;
  assign load_o      = ldp_q[1];
  assign load_byte_o = (st_q == ST_STAT) ? (busy_i ? 8'hFF : status_i) : rd_data_i;
  assign drive_o     = (st_q == ST_RDAT) || (st_q == ST_STAT);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_o, wrdi_o, wrsr_o, wbyte_o}));

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RDAT && $past(st_q) == ST_RDAT && addr_q != $past(addr_q))
      |-> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  // R6
  busy_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && st_q == ST_OPC) |=> !(wren_o || wrdi_o));

  // R7
  ign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGN && !cs_fall_i) |=> (st_q == ST_IGN || st_q == ST_IDLE));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W     = 11,
  parameter int ADDR_PHASE = 16,
  parameter int PAGE_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wren_o,
  output logic              wrdi_o,
  output logic              wrsr_o,
  output logic              wbyte_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              cmd_end_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] pins_s, pins_d;
  logic sck_s, sck_d, cs_s, cs_d, si_s, hold_s;
  logic hold_q, hold_n;
  logic live, sck_rise, sck_fall, cs_fall, cs_rise;
  logic load, drive;
  logic [7:0] load_byte;

  spi_in_sync #(.N(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({hold_n_i, si_i, ~cs_n_i, sck_i}),
    .q_o(pins_s), .qd_o(pins_d)
  );

  assign sck_s  = pins_s[0];
  assign sck_d  = pins_d[0];
  assign cs_s   = ~pins_s[1];
  assign cs_d   = ~pins_d[1];
  assign si_s   = pins_s[2];
  assign hold_s = pins_s[3];

  always_comb begin
    hold_n = hold_q;
    if (cs_s)        hold_n = 1'b0;
    else if (!sck_s) hold_n = !hold_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_n;
  end

  assign live     = !cs_s && !hold_q;
  assign sck_rise = live && sck_s && !sck_d;
  assign sck_fall = live && !sck_s && sck_d;
  assign cs_fall  = !cs_s && cs_d;
  assign cs_rise  = cs_s && !cs_d;

  spi_cmd_fsm #(.ADDR_W(ADDR_W), .ADDR_PHASE(ADDR_PHASE), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise_i(sck_rise), .cs_fall_i(cs_fall),
    .cs_rise_i(cs_rise), .si_i(si_s), .busy_i(busy_i), .status_i(status_i),
    .rd_data_i(rd_data_i), .rd_addr_o(rd_addr_o), .load_o(load),
    .load_byte_o(load_byte), .drive_o(drive), .wren_o(wren_o),
    .wrdi_o(wrdi_o), .wrsr_o(wrsr_o), .wbyte_o(wbyte_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .cmd_end_o(cmd_end_o)
  );

  spi_tx_shift #(.W(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(load), .byte_i(load_byte),
    .shift_i(sck_fall), .so_o(so_o)
  );

  assign so_oe_o = live && drive;

  // R11
  oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2)) |-> !so_oe_o);

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q)) |-> $stable(so_o));
endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status = 8'h0C, rd_data;
  logic so, so_oe, wren, wrdi, wrsr, wbyte, cmd_end;
  logic [10:0] rd_addr, wr_addr;
  logic [7:0] wr_data;
  int checks = 0, fails = 0;
  bit mode3 = 1'b0, done = 1'b0;

  typedef struct {int kind; int addr; int data; string req;} item_t;
  item_t q[$];

  always #10 clk = ~clk;

  spi_mem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .hold_n_i(hold_n), .so_o(so), .so_oe_o(so_oe), .busy_i(busy),
    .status_i(status), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wren_o(wren), .wrdi_o(wrdi), .wrsr_o(wrsr), .wbyte_o(wbyte),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .cmd_end_o(cmd_end)
  );

  function automatic logic [7:0] memf(input int a);
    return 8'(a) ^ {5'b10110, 3'(a >> 8)};
  endfunction

  always_ff @(posedge clk) rd_data <= memf(int'(rd_addr));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input int k, input int a, input int d, input string r);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.req = r;
    q.push_back(it);
  endtask

  task automatic mon_cmp(input int k, input int a, input int d);
    item_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R6 R7", "unexpected strobe kind", k, 0);
    end else begin
      e = q.pop_front();
      chk(e.kind == k && e.addr == a && e.data == d, e.req, "strobe kind/addr/data",
          (k << 24) | (a << 8) | d, (e.kind << 24) | (e.addr << 8) | e.data);
    end
  endtask

  // monitor: kinds 1 wren, 2 wrdi, 3 wrsr, 4 wbyte, 5 end
  always @(negedge clk) begin
    if (rst_n) begin
      if (wren)    mon_cmp(1, 0, 0);
      if (wrdi)    mon_cmp(2, 0, 0);
      if (wrsr)    mon_cmp(3, 0, int'(wr_data));
      if (wbyte)   mon_cmp(4, int'(wr_addr), int'(wr_data));
      if (cmd_end) mon_cmp(5, 0, 0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic o, output logic oe);
    if (mode3) sck = 1'b0;
    si = b;
    wait_clk(8);
    o = so; oe = so_oe;
    sck = 1'b1;
    wait_clk(8);
    if (!mode3) sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    logic o, oe;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], o, oe);
      rx[i] = o;
      oe_any = oe_any | oe;
    end
  endtask

  task automatic cs_lo();
    sck = mode3;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(8);
  endtask

  task automatic cs_hi();
    wait_clk(4);
    expect_item(5, 0, 0, "R11");
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic read_run(input logic [15:0] a, input int n, input string r);
    logic [7:0] rx;
    logic oe;
    cs_lo();
    byte_x(8'h03, rx, oe);
    byte_x(a[15:8], rx, oe);
    byte_x(a[7:0], rx, oe);
    for (int i = 0; i < n; i++) begin
      byte_x(8'h00, rx, oe);
      chk(rx == memf((int'(a) + i) & 16'h7FF), r, "read byte", rx,
          memf((int'(a) + i) & 16'h7FF));
      chk(oe, r, "output enabled during read", oe, 1);
    end
    cs_hi();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    logic [7:0] rx;
    logic oe, o, o2;
    wait_clk(5);
    // R1: reset state
    chk(so_oe == 1'b0, "R1", "so_oe in reset", so_oe, 0);
    rst_n = 1'b1;
    wait_clk(10);
    chk(so_oe == 1'b0 && !wren && !wbyte && !cmd_end, "R1", "idle after reset", so_oe, 0);

    // R2: enable / disable strobes
    cs_lo(); expect_item(1, 0, 0, "R2"); byte_x(8'h06, rx, oe);
    chk(!oe, "R2", "no drive for 0x06", oe, 0); cs_hi();
    cs_lo(); expect_item(2, 0, 0, "R2"); byte_x(8'h04, rx, oe);
    chk(!oe, "R2", "no drive for 0x04", oe, 0); cs_hi();

    // R3 R4: read with junk upper address bits, then top-of-array wrap
    read_run(16'hF805, 3, "R3");
    read_run(16'h07FE, 3, "R4");
    // R12: mode 3
    mode3 = 1'b1;
    read_run(16'h0123, 2, "R12");
    mode3 = 1'b0; sck = 1'b0; wait_clk(8);

    // R5: status read, plain and busy; busy released mid-byte
    cs_lo(); byte_x(8'h05, rx, oe);
    byte_x(8'h00, rx, oe); chk(rx == status, "R5", "status byte", rx, status);
    byte_x(8'h00, rx, oe); chk(rx == status, "R5", "status repeat", rx, status);
    cs_hi();
    busy = 1'b1;
    cs_lo(); byte_x(8'h05, rx, oe);
    byte_x(8'h00, rx, oe); chk(rx == 8'hFF, "R5", "busy status", rx, 8'hFF);
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b0, o, oe);
      rx[i] = o;
      if (i == 4) busy = 1'b0;
    end
    chk(rx == 8'hFF, "R5", "byte loaded while busy", rx, 8'hFF);
    byte_x(8'h00, rx, oe); chk(rx == status, "R5", "after busy release", rx, status);
    cs_hi();

    // R6: other opcodes ignored while busy
    busy = 1'b1;
    cs_lo(); byte_x(8'h06, rx, oe); cs_hi();
    cs_lo(); byte_x(8'h03, rx, oe); byte_x(8'h00, rx, oe); byte_x(8'h10, rx, oe);
    byte_x(8'h00, rx, oe); chk(!oe, "R6", "no drive for read while busy", oe, 0);
    cs_hi();
    busy = 1'b0;

    // R7: unknown opcode, later bits ignored
    cs_lo(); byte_x(8'h55, rx, oe); byte_x(8'h06, rx, oe); byte_x(8'h03, rx, oe);
    chk(!oe, "R7", "no drive after unknown opcode", oe, 0); cs_hi();

    // R8: page write with wrap inside the page; R11 partial byte dropped
    cs_lo(); byte_x(8'h02, rx, oe); byte_x(8'hA0, rx, oe); byte_x(8'h3E, rx, oe);
    expect_item(4, 11'h03E, 8'hA1, "R8"); byte_x(8'hA1, rx, oe);
    expect_item(4, 11'h03F, 8'hA2, "R8"); byte_x(8'hA2, rx, oe);
    expect_item(4, 11'h020, 8'hA3, "R8"); byte_x(8'hA3, rx, oe);
    for (int i = 0; i < 4; i++) bit_x(1'b1, o, oe);
    cs_hi();

    // R9: status write
    cs_lo(); byte_x(8'h01, rx, oe);
    expect_item(3, 0, 8'h8C, "R9"); byte_x(8'h8C, rx, oe); cs_hi();

    // R10: pause during address phase (junk SI ignored) and data phase
    cs_lo(); byte_x(8'h03, rx, oe); byte_x(8'h02, rx, oe);
    for (int i = 7; i >= 4; i--) bit_x(logic'(i == 6), o, oe);
    hold_n = 1'b0; wait_clk(8);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; sck = 1'b1; wait_clk(8); sck = 1'b0; wait_clk(8);
    end
    hold_n = 1'b1; wait_clk(8);
    for (int i = 3; i >= 0; i--) bit_x(logic'(i == 1), o, oe);
    for (int i = 7; i >= 5; i--) begin bit_x(1'b0, o, oe); rx[i] = o; end
    hold_n = 1'b0; wait_clk(8);
    o2 = so_oe;
    chk(!o2, "R10", "output off while paused", o2, 0);
    for (int i = 0; i < 2; i++) begin
      sck = 1'b1; wait_clk(8); sck = 1'b0; wait_clk(8);
    end
    hold_n = 1'b1; wait_clk(8);
    for (int i = 4; i >= 0; i--) begin bit_x(1'b0, o, oe); rx[i] = o; end
    chk(rx == memf(16'h242), "R10", "byte across pause", rx, memf(16'h242));
    byte_x(8'h00, rx, oe);
    chk(rx == memf(16'h243), "R10", "byte after pause", rx, memf(16'h243));
    cs_hi();
    chk(!so_oe, "R11", "output off after select high", so_oe, 0);

    wait_clk(20);
    chk(q.size() == 0, "R11", "all expected strobes seen", q.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule